// File: doc/BRIEF.md
# Sequential Viterbi Add-Compare-Select Engine

This block carries out one trellis step of a Viterbi decoder for a rate-1/2 convolutional code of constraint length C. The code has 2^(C-1) encoder states. Before a step, the host writes the present accumulated cost of every state through a load port. A single start pulse then captures the received two-bit symbol and the two generator polynomials. From that point the engine visits the destination states in ascending order, one per clock cycle. It uses one shared add-compare-select datapath for all of them.

For each destination state the engine forms a Hamming branch metric for each of the two incoming transitions. It adds each metric to the cost of the matching predecessor, saturating the sum, and keeps the smaller result. The new cost and the decision bit leave the block on a per-state step stream, which feeds the survivor memory. The new cost is also written into a second cost bank. While the sweep runs, the engine tracks the index of the cheapest state. When the last state is done, the two banks swap roles, so the next trellis step reads the new costs straight away.

Top module: `vacs_engine`

## Requirements
- R1: After reset, busy, done and step_valid are 0, min_state is 0, and every present cost read through rd_idx/rd_cost is 0.
- R2: When idle, a cycle with ld_en high writes ld_cost into the present cost of state ld_idx. rd_cost shows the present cost of state rd_idx combinationally. ld_en is ignored while busy.
- R3: A start pulse while idle captures rx_sym, poly_a and poly_b and raises busy on the next cycle. On the cycles after that, step_valid is high for exactly 2^(C-1) consecutive cycles, with step_state counting 0, 1, 2, and so on up to 2^(C-1)-1.
- R4: Destination state K has two predecessors, P = ((K<<1)|x) mod 2^(C-1) for x = 0 and x = 1. The encoder word of that transition is the C-bit value {K, x}, with K in the upper C-1 bits and x in bit 0. The expected pair has bit 0 = parity(word & poly_a) and bit 1 = parity(word & poly_b). The branch metric is the number of bits in which this pair differs from the captured symbol. step_cost is the smaller of the two candidate sums, present cost of P plus metric.
- R5: step_bit is the x of the chosen transition. When the two sums are equal, x = 0 (the lower-numbered predecessor) wins.
- R6: Candidate sums saturate at 255 (8-bit costs) and never wrap.
- R7: done is high for exactly one cycle, together with the step of the last state. From that cycle on, rd_cost returns the costs computed in the sweep.
- R8: When done is high, min_state is the lowest-numbered state among those holding the smallest new cost.
- R9: A start pulse while busy is ignored: the sweep neither restarts nor stretches.
- R10: Changes to rx_sym, poly_a and poly_b during a sweep have no effect on that sweep's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one trellis step |
| rx_sym | input | 2 | Received symbol pair |
| poly_a | input | C | Generator polynomial for symbol bit 0 |
| poly_b | input | C | Generator polynomial for symbol bit 1 |
| ld_en | input | 1 | Write a present-state cost |
| ld_idx | input | C-1 | State written by ld_en |
| ld_cost | input | 8 | Cost value written |
| rd_idx | input | C-1 | State whose present cost is shown |
| rd_cost | output | 8 | Present cost of state rd_idx |
| busy | output | 1 | Sweep in progress |
| step_valid | output | 1 | One destination state finished |
| step_state | output | C-1 | State finished this cycle |
| step_bit | output | 1 | Survivor decision (winning x) |
| step_cost | output | 8 | New cost of step_state |
| done | output | 1 | Single-cycle end-of-sweep pulse |
| min_state | output | C-1 | Index of the cheapest state so far |

## Verification
Several kinds of sweep are run:
- Sweeps with random costs, symbols and polynomials, which separate correct predecessor selection and metric computation from swapped or misindexed variants.
- Sweeps with all-zero polynomials and equal costs, which force ties everywhere, so that only the lower-predecessor tie rule and the lowest-index minimum rule can produce the expected bits and index.
- Sweeps with costs near the top of the range, which separate saturation from wraparound.
- Sweeps with start, symbol, polynomial and load activity injected in mid-sweep, which tell input capture at start apart from live use of the inputs.

Chained sweeps without reloading confirm that the banks swap at the end of each sweep.

// File: rtl/vacs_pkg.sv
package vacs_pkg;
  typedef enum logic {ST_IDLE, ST_SWEEP} sweep_e;
  typedef logic [1:0] metric_t;
endpackage

// File: rtl/vacs_rst_sync.sv
module vacs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_n  <= meta_q;
    end
  end
endmodule

// File: rtl/vacs_bmu.sv
module vacs_bmu
  import vacs_pkg::*;
#(
  parameter int C_LEN = 3
) (
  input  logic [C_LEN-2:0] dst,
  input  logic [C_LEN-1:0] poly_a,
  input  logic [C_LEN-1:0] poly_b,
  input  logic [1:0]       sym,
  output metric_t          bm_even,
  output metric_t          bm_odd
);
  metric_t bm [2];

  for (genvar x = 0; x < 2; x++) begin : g_tr
    logic [C_LEN-1:0] word;
    logic [1:0]       expd;
    logic [1:0]       diff;
    assign word  = {dst, 1'(x)};
    assign expd  = {^(word & poly_b), ^(word & poly_a)};
    assign diff  = expd ^ sym;
    assign bm[x] = {diff[1] & diff[0], diff[1] ^ diff[0]};
  end

  assign bm_even = bm[0];
  assign bm_odd  = bm[1];
endmodule

// File: rtl/vacs_acs.sv
module vacs_acs
  import vacs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cost_even,
  input  logic [CW-1:0] cost_odd,
  input  metric_t       bm_even,
  input  metric_t       bm_odd,
  output logic [CW-1:0] new_cost,
  output logic          pick_odd
);
  logic [CW:0]   sum_e, sum_o;
  logic [CW-1:0] sat_e, sat_o;

  always_comb begin
    sum_e = {1'b0, cost_even} + (CW+1)'(bm_even);
    sum_o = {1'b0, cost_odd}  + (CW+1)'(bm_odd);
    sat_e = sum_e[CW] ? {CW{1'b1}} : sum_e[CW-1:0];
    sat_o = sum_o[CW] ? {CW{1'b1}} : sum_o[CW-1:0];
    // strict compare: ties keep the even (lower) predecessor
    pick_odd = (sat_o < sat_e);
    new_cost = pick_odd ? sat_o : sat_e;
  end
endmodule

// File: rtl/vacs_engine.sv
module vacs_engine
  import vacs_pkg::*;
#(
  parameter int C_LEN = 3,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start,
  input  logic [1:0]       rx_sym,
  input  logic [C_LEN-1:0] poly_a,
  input  logic [C_LEN-1:0] poly_b,
  input  logic             ld_en,
  input  logic [C_LEN-2:0] ld_idx,
  input  logic [CW-1:0]    ld_cost,
  input  logic [C_LEN-2:0] rd_idx,
  output logic [CW-1:0]    rd_cost,
  output logic             busy,
  output logic             step_valid,
  output logic [C_LEN-2:0] step_state,
  output logic             step_bit,
  output logic [CW-1:0]    step_cost,
  output logic             done,
  output logic [C_LEN-2:0] min_state
);
  localparam int SW = C_LEN - 1;
  localparam int NS = 1 << SW;
  localparam logic [SW-1:0] LAST = SW'(NS - 1);

  logic rst_n;
  vacs_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  sweep_e           st_q, st_d;
  logic [SW-1:0]    k_q, k_d;
  logic             sel_q, sel_d;
  logic [1:0]       sym_q, sym_d;
  logic [C_LEN-1:0] pa_q, pa_d, pb_q, pb_d;
  logic             sv_q, sv_d, sb_q, sb_d, done_q, done_d;
  logic [SW-1:0]    ss_q, ss_d, min_idx_q, min_idx_d;
  logic [CW-1:0]    sc_q, sc_d, min_cost_q, min_cost_d;
  logic [CW-1:0]    bank_q [2][NS];

  logic          sweeping, last, ld_take;
  logic [SW-1:0] p_even, p_odd;
  logic [CW-1:0] cost_even, cost_odd, acs_cost;
  metric_t       bm_even, bm_odd;
  logic          acs_pick;

  assign sweeping  = (st_q == ST_SWEEP);
  assign last      = (k_q == LAST);
  assign ld_take   = ld_en && !sweeping;
  assign p_even    = SW'({k_q, 1'b0});
  assign p_odd     = p_even | SW'(1);
  assign cost_even = bank_q[sel_q][p_even];
  assign cost_odd  = bank_q[sel_q][p_odd];

  vacs_bmu #(.C_LEN(C_LEN)) u_bmu (
    .dst(k_q), .poly_a(pa_q), .poly_b(pb_q), .sym(sym_q),
    .bm_even(bm_even), .bm_odd(bm_odd)
  );

  vacs_acs #(.CW(CW)) u_acs (
    .cost_even(cost_even), .cost_odd(cost_odd),
    .bm_even(bm_even), .bm_odd(bm_odd),
    .new_cost(acs_cost), .pick_odd(acs_pick)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    k_d        = k_q;
    sel_d      = sel_q;
    sym_d      = sym_q;
    pa_d       = pa_q;
    pb_d       = pb_q;
    min_idx_d  = min_idx_q;
    min_cost_d = min_cost_q;
    sv_d       = sweeping;
    ss_d       = sweeping ? k_q : ss_q;
    sb_d       = sweeping ? acs_pick : sb_q;
    sc_d       = sweeping ? acs_cost : sc_q;
    done_d     = sweeping && last;
    if (!sweeping) begin
      if (start) begin
        st_d  = ST_SWEEP;
        k_d   = '0;
        sym_d = rx_sym;
        pa_d  = poly_a;
        pb_d  = poly_b;
      end
    end else begin
      k_d = k_q + SW'(1);
      if (last) begin
        st_d  = ST_IDLE;
        sel_d = ~sel_q;
      end
      if ((k_q == '0) || (acs_cost < min_cost_q)) begin
        min_idx_d  = k_q;
        min_cost_d = acs_cost;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      k_q        <= '0;
      sel_q      <= 1'b0;
      sym_q      <= '0;
      pa_q       <= '0;
      pb_q       <= '0;
      sv_q       <= 1'b0;
      ss_q       <= '0;
      sb_q       <= 1'b0;
      sc_q       <= '0;
      done_q     <= 1'b0;
      min_idx_q  <= '0;
      min_cost_q <= '0;
    end else begin
      st_q       <= st_d;
      k_q        <= k_d;
      sel_q      <= sel_d;
      sym_q      <= sym_d;
      pa_q       <= pa_d;
      pb_q       <= pb_d;
      sv_q       <= sv_d;
      ss_q       <= ss_d;
      sb_q       <= sb_d;
      sc_q       <= sc_d;
      done_q     <= done_d;
      min_idx_q  <= min_idx_d;
      min_cost_q <= min_cost_d;
    end
  end

  // cost banks: present bank takes loads, other bank takes sweep results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NS; s++)
          bank_q[b][s] <= '0;
    end else begin
      if (ld_take)  bank_q[sel_q][ld_idx] <= ld_cost;
      if (sweeping) bank_q[~sel_q][k_q]   <= acs_cost;
    end
  end

  assign rd_cost    = bank_q[sel_q][rd_idx];
  assign busy       = sweeping;
  assign step_valid = sv_q;
  assign step_state = ss_q;
  assign step_bit   = sb_q;
  assign step_cost  = sc_q;
  assign done       = done_q;
  assign min_state  = min_idx_q;
endmodule

// File: rtl/vacs_engine_chk.sv
module vacs_engine_chk #(
  parameter int C_LEN = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             step_valid,
  input logic [C_LEN-2:0] step_state,
  input logic             done
);
  localparam int SW = C_LEN - 1;
  localparam logic [SW-1:0] LAST = SW'((1 << SW) - 1);

  // R3
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && $past(step_valid)) |-> (step_state == $past(step_state) + SW'(1)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step_valid && step_state == LAST));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_state != LAST) |-> busy);
endmodule

bind vacs_engine vacs_engine_chk #(.C_LEN(C_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .step_valid(step_valid), .step_state(step_state), .done(done)
);

// File: tb/vacs_engine_test.sv
module vacs_engine_test;
  localparam int C_LEN = 3;
  localparam int CW    = 8;
  localparam int SW    = C_LEN - 1;
  localparam int NS    = 1 << SW;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk, arst_n, start, ld_en;
  logic [1:0] rx_sym;
  logic [C_LEN-1:0] poly_a, poly_b;
  logic [SW-1:0] ld_idx, rd_idx, step_state, min_state;
  logic [CW-1:0] ld_cost, rd_cost, step_cost;
  logic busy, step_valid, step_bit, done;

  vacs_engine #(.C_LEN(C_LEN), .CW(CW)) uut (
    .clk(clk), .arst_n(arst_n), .start(start), .rx_sym(rx_sym),
    .poly_a(poly_a), .poly_b(poly_b), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_cost(ld_cost), .rd_idx(rd_idx), .rd_cost(rd_cost), .busy(busy),
    .step_valid(step_valid), .step_state(step_state), .step_bit(step_bit),
    .step_cost(step_cost), .done(done), .min_state(min_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit m_on = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  // behavioural reference model
  int mc [2][NS];
  int m_sel, m_busy, m_k, m_sym, m_pa, m_pb;
  int m_sv, m_ss, m_sb, m_sc, m_done, m_min, m_minc;

  function automatic int par(int v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c & 1;
  endfunction

  function automatic int metric(int k, int x);
    int w = k * 2 + x;
    int d = 0;
    if (par(w & m_pa) != (m_sym & 1)) d++;
    if (par(w & m_pb) != ((m_sym >> 1) & 1)) d++;
    return d;
  endfunction

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  always @(posedge clk) begin
    if (m_on) begin
      if (m_busy == 0) begin
        m_sv = 0; m_done = 0;
        if (ld_en) mc[m_sel][ld_idx] = ld_cost;
        if (start) begin
          m_busy = 1; m_k = 0;
          m_sym = rx_sym; m_pa = poly_a; m_pb = poly_b;
        end
      end else begin
        int pe, s0, s1, c, b;
        pe = (2 * m_k) % NS;
        s0 = sat(mc[m_sel][pe] + metric(m_k, 0));
        s1 = sat(mc[m_sel][pe + 1] + metric(m_k, 1));
        if (s1 < s0) begin c = s1; b = 1; end else begin c = s0; b = 0; end
        mc[1 - m_sel][m_k] = c;
        m_sv = 1; m_ss = m_k; m_sb = b; m_sc = c;
        if (m_k == 0 || c < m_minc) begin m_min = m_k; m_minc = c; end
        if (m_k == NS - 1) begin
          m_busy = 0; m_done = 1; m_sel = 1 - m_sel;
        end else begin
          m_k++; m_done = 0;
        end
      end
    end
  end

  int sb_or = 0;
  always @(negedge clk) begin
    if (m_on) begin
      chk("R9", "busy", busy, m_busy);
      chk("R3", "step_valid", step_valid, m_sv);
      if (m_sv != 0) begin
        chk("R3", "step_state", step_state, m_ss);
        chk("R5", "step_bit", step_bit, m_sb);
        chk("R4", "step_cost", step_cost, m_sc);
        sb_or |= step_bit;
      end
      chk("R7", "done", done, m_done);
      if (m_done != 0) chk("R8", "min_state", min_state, m_min);
      chk("R2", "rd_cost", rd_cost, mc[m_sel][rd_idx]);
    end
  end

  task automatic load(int idx, int val);
    @(negedge clk); #1;
    ld_en = 1; ld_idx = SW'(idx); ld_cost = CW'(val);
    @(negedge clk); #1;
    ld_en = 0;
  endtask

  task automatic load_all(int v0, int v1, int v2, int v3);
    load(0, v0); load(1, v1); load(2, v2); load(3, v3);
  endtask

  task automatic sweep(int s, int a, int b);
    @(negedge clk); #1;
    start = 1; rx_sym = 2'(s); poly_a = C_LEN'(a); poly_b = C_LEN'(b);
    @(negedge clk); #1;
    start = 0;
    repeat (NS + 2) @(negedge clk);
  endtask

  task automatic verify_bank(string tag);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); #1;
      rd_idx = SW'(i);
      #1;
      chk(tag, "bank cost", rd_cost, mc[m_sel][i]);
    end
  endtask

  initial begin
    arst_n = 0; start = 0; ld_en = 0; rx_sym = 0;
    poly_a = 0; poly_b = 0; ld_idx = 0; ld_cost = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++) mc[b][s] = 0;
    m_sel = 0; m_busy = 0; m_k = 0; m_sym = 0; m_pa = 0; m_pb = 0;
    m_sv = 0; m_ss = 0; m_sb = 0; m_sc = 0; m_done = 0; m_min = 0; m_minc = 0;
    m_on = 1;

    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "step_valid", step_valid, 0);
    chk("R1", "min_state", min_state, 0);
    for (int i = 0; i < NS; i++) begin
      rd_idx = SW'(i); #1;
      chk("R1", "rd_cost", rd_cost, 0);
    end

    // R2 R4 basic sweeps, then chained without reload (R7 swap)
    load_all(0, 3, 5, 2);
    verify_bank("R2");
    sweep(3, 7, 5);
    verify_bank("R7");
    sweep(0, 7, 5);
    sweep(2, 6, 3);
    verify_bank("R7");

    // R5 R8 ties everywhere
    load_all(4, 4, 4, 4);
    sb_or = 0;
    sweep(1, 0, 0);
    chk("R5", "tie decision bits", sb_or, 0);
    chk("R8", "tie min_state", min_state, 0);

    // R6 saturation
    load_all(254, 255, 253, 250);
    sweep(3, 0, 0);
    verify_bank("R6");
    chk("R6", "saturated cost", mc[m_sel][0], CMAX);

    // R9 R10 activity during a sweep
    load_all(10, 20, 7, 9);
    @(negedge clk); #1;
    start = 1; rx_sym = 2; poly_a = 7; poly_b = 5;
    @(negedge clk); #1;
    start = 0;
    @(negedge clk); #1;
    start = 1; rx_sym = 1; poly_a = 6; poly_b = 3;
    ld_en = 1; ld_idx = 0; ld_cost = 99;
    @(negedge clk); #1;
    start = 0; ld_en = 0;
    repeat (NS + 2) @(negedge clk);
    verify_bank("R10");
    chk("R9", "busy after sweep", busy, 0);

    // R4 R8 random sweeps
    for (int it = 0; it < 10; it++) begin
      load_all($urandom_range(0, 255), $urandom_range(0, 255),
               $urandom_range(0, 255), $urandom_range(0, 255));
      sweep($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7));
      verify_bank("R4");
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule